// File: doc/BRIEF.md
# Sample Buffer with Interrupt Status

This block sits between an analog-to-digital converter and a host bus. Each finished conversion arrives as a 12-bit result plus a 4-bit channel tag. The block packs the pair into a 16-bit word and queues it in a deep first-in first-out store. The host pops the words with 16-bit reads at the data offset.

A small flag controller tracks two conditions: data ready and overrun. The host reads them at the status offset. A write of any value to the clear offset drops the ready flag. A control register holds the interrupt enable, the pacer mode and the encoded interrupt-line field. The interrupt request output combines the enable bit with the two flags.

The flag controller is a four-state machine over the pair {ready, overrun}:
- ST_QUIET: neither flag is set.
- ST_READY: only ready is set.
- ST_OVRUN: only overrun is set.
- ST_BOTH: both flags are set.

Three events raise flags. A raise (an accepted conversion, or a fill level of at least half the depth) moves the machine to a state that includes ready. A drop (a conversion offered while the store is full) moves it to a state that includes overrun.

Two events lower flags. A clear write leaves the states with ready, but only when no raise happens in the same cycle. A disarm (a control write whose pacer bits are 00) leaves the states with overrun, but only when no drop happens in the same cycle. Every other cycle holds the current state.

Top module: `sfifo_irq_top`

## Requirements
- R1: The store holds DEPTH (default 1024) words. A host read at offset 0 pops the oldest word, so words come out in arrival order.
- R2: A popped word carries the 12-bit result in bits 15:4 and the channel tag in bits 3:0. It appears on host_rdata in the cycle after the read strobe and holds until the next read.
- R3: A read at offset 0 while the store is empty returns the last word popped (0 after reset) and does not change the fill level.
- R4: A read at offset 2 returns the status byte: bit 7 is ready, bit 5 is overrun, and every other bit is 0. Bits 15:8 of host_rdata are 0 for every read that is not a data read.
- R5: Every accepted conversion sets ready. A write of any value to offset 4 clears ready.
- R6: While the store holds at least DEPTH/2 words, ready stays set, and a clear write has no effect on it.
- R7: A conversion offered while the store is full is dropped and sets overrun. Overrun is sticky: a clear write does not lower it. Only a control write with bits 1:0 equal to 00 clears it.
- R8: Offset 5 is the control register. A write stores wdata bit 7 (interrupt enable) and bits 1:0 (pacer mode: 00 disabled, 10 external, 11 internal). A read returns the register, with bits 3:2 reading 0.
- R9: On each control write, bits 6:4 take the code of line_num: 10→0, 11→1, 12→2, 15→3, 2→4, 3→5, 5→6, 7→7. For any other line number the field keeps its previous value. Bits 6:4 of wdata are ignored.
- R10: irq_out equals control bit 7 AND (ready OR overrun).
- R11: After reset the store is empty, both flags are clear, the control register is 0, host_rdata is 0 and irq_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cv_valid | input | 1 | A finished conversion is offered this cycle |
| cv_value | input | 12 | Conversion result |
| cv_chan | input | 4 | Channel tag of the conversion |
| host_addr | input | 4 | Register offset |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| line_num | input | 4 | Interrupt line number to encode into the control register |
| host_rdata | output | 16 | Read data, valid the cycle after the read strobe |
| irq_out | output | 1 | Interrupt request |

## Verification
A pointer or count error inside the store shows at the ports within one read. A popped word then differs from the one the bench computed for that position, or an empty read returns a new value. A wrong flag state shows on the next status read and immediately on irq_out once the enable is set. The bench therefore fills the store past half-full and into overflow, then drains it completely. It compares every word and samples the status at each boundary. It also sweeps all sixteen line numbers through the encoder.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    typedef enum logic [1:0] {
        ST_QUIET = 2'd0,
        ST_READY = 2'd1,
        ST_OVRUN = 2'd2,
        ST_BOTH  = 2'd3
    } flag_state_t;

    localparam logic [3:0] OFS_DATA  = 4'd0;
    localparam logic [3:0] OFS_STAT  = 4'd2;
    localparam logic [3:0] OFS_CLEAR = 4'd4;
    localparam logic [3:0] OFS_CTRL  = 4'd5;

    localparam int STAT_READY_BIT = 7;
    localparam int STAT_OVR_BIT   = 5;
    localparam int CTRL_EN_BIT    = 7;

    // returns {valid, code[2:0]}
    function automatic logic [3:0] encode_line(input logic [3:0] n);
        logic [3:0] r;
        unique case (n)
            4'd10:   r = 4'b1_000;
            4'd11:   r = 4'b1_001;
            4'd12:   r = 4'b1_010;
            4'd15:   r = 4'b1_011;
            4'd2:    r = 4'b1_100;
            4'd3:    r = 4'b1_101;
            4'd5:    r = 4'b1_110;
            4'd7:    r = 4'b1_111;
            default: r = 4'b0_000;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sfifo_store.sv
module sfifo_store #(
    parameter int DEPTH  = 1024,
    parameter int WORD_W = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [WORD_W-1:0] push_word,
    input  logic              pop_req,
    output logic [WORD_W-1:0] last_word,
    output logic [CW-1:0]     fill_cnt,
    output logic              push_ok,
    output logic              push_drop
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr_q, rptr_q;
    logic [CW-1:0]     cnt_q;
    logic              pop_ok;

    assign pop_ok    = pop_req && (cnt_q != '0);
    assign push_ok   = push_req && ((cnt_q != CW'(DEPTH)) || pop_ok);
    assign push_drop = push_req && !push_ok;
    assign fill_cnt  = cnt_q;

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr_q] <= push_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q    <= '0;
            rptr_q    <= '0;
            cnt_q     <= '0;
            last_word <= '0;
        end else begin
            if (push_ok) wptr_q <= wptr_q + 1'b1;
            if (pop_ok) begin
                rptr_q    <= rptr_q + 1'b1;
                last_word <= mem[rptr_q];
            end
            unique case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/sfifo_flags.sv
module sfifo_flags
    import sfifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic hold_lvl,
    input  logic clr_req,
    input  logic drop_evt,
    input  logic disarm,
    output logic ready,
    output logic ovr
);
    flag_state_t state_q, state_d;
    logic raise, keep_r, keep_o;

    assign raise  = set_evt || hold_lvl;
    assign keep_r = raise || !clr_req;
    assign keep_o = drop_evt || !disarm;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: begin
                if (drop_evt)   state_d = raise ? ST_BOTH : ST_OVRUN;
                else if (raise) state_d = ST_READY;
            end
            ST_READY: begin
                if (drop_evt)     state_d = keep_r ? ST_BOTH : ST_OVRUN;
                else if (!keep_r) state_d = ST_QUIET;
            end
            ST_OVRUN: begin
                if (raise) state_d = keep_o ? ST_BOTH : ST_READY;
                else       state_d = keep_o ? ST_OVRUN : ST_QUIET;
            end
            ST_BOTH: begin
                unique case ({keep_r, keep_o})
                    2'b11: state_d = ST_BOTH;
                    2'b10: state_d = ST_READY;
                    2'b01: state_d = ST_OVRUN;
                    default: state_d = ST_QUIET;
                endcase
            end
            default: state_d = ST_QUIET;
        endcase
    end

    always_comb begin
        ready = (state_q == ST_READY) || (state_q == ST_BOTH);
        ovr   = (state_q == ST_OVRUN) || (state_q == ST_BOTH);
    end
endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
    import sfifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  logic [3:0] line_num,
    output logic [7:0] ctrl_q,
    output logic       disarm
);
    logic [3:0] code;

    assign code   = encode_line(line_num);
    assign disarm = wr_en && (wdata[1:0] == 2'b00);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q[CTRL_EN_BIT] <= wdata[CTRL_EN_BIT];
            ctrl_q[1:0]         <= wdata[1:0];
            ctrl_q[3:2]         <= 2'b00;
            if (code[3]) ctrl_q[6:4] <= code[2:0];
        end
    end
endmodule

// File: rtl/sfifo_irq_top.sv
module sfifo_irq_top
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int VAL_W = 12,
    parameter int TAG_W = 4,
    localparam int WORD_W = VAL_W + TAG_W,
    localparam int CW = $clog2(DEPTH) + 1,
    localparam int HALF = DEPTH / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cv_valid,
    input  logic [VAL_W-1:0]  cv_value,
    input  logic [TAG_W-1:0]  cv_chan,
    input  logic [3:0]        host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [7:0]        host_wdata,
    input  logic [3:0]        line_num,
    output logic [WORD_W-1:0] host_rdata,
    output logic              irq_out
);
    logic [WORD_W-1:0] last_word;
    logic [CW-1:0]     fill_cnt;
    logic              push_ok, push_drop, pop_req, clr_req, ctrl_wr, disarm;
    logic              ready_flag, ovr_flag, hold_lvl;
    logic [7:0]        ctrl_q, stat_byte, snap_q;
    logic              rd_data_q;

    assign pop_req  = host_rd && (host_addr == OFS_DATA);
    assign clr_req  = host_wr && (host_addr == OFS_CLEAR);
    assign ctrl_wr  = host_wr && (host_addr == OFS_CTRL);
    assign hold_lvl = (fill_cnt >= CW'(HALF));

    sfifo_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .push_req(cv_valid), .push_word({cv_value, cv_chan}),
        .pop_req(pop_req), .last_word(last_word), .fill_cnt(fill_cnt),
        .push_ok(push_ok), .push_drop(push_drop)
    );

    sfifo_flags u_flags (
        .clk(clk), .rst_n(rst_n),
        .set_evt(push_ok), .hold_lvl(hold_lvl), .clr_req(clr_req),
        .drop_evt(push_drop), .disarm(disarm),
        .ready(ready_flag), .ovr(ovr_flag)
    );

    sfifo_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr), .wdata(host_wdata),
        .line_num(line_num), .ctrl_q(ctrl_q), .disarm(disarm)
    );

    always_comb begin
        stat_byte = '0;
        stat_byte[STAT_READY_BIT] = ready_flag;
        stat_byte[STAT_OVR_BIT]   = ovr_flag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q <= 1'b0;
            snap_q    <= '0;
        end else if (host_rd) begin
            rd_data_q <= (host_addr == OFS_DATA);
            unique case (host_addr)
                OFS_STAT: snap_q <= stat_byte;
                OFS_CTRL: snap_q <= ctrl_q;
                default:  snap_q <= '0;
            endcase
        end
    end

    assign host_rdata = rd_data_q ? last_word : {{(WORD_W-8){1'b0}}, snap_q};
    assign irq_out    = ctrl_q[CTRL_EN_BIT] && (ready_flag || ovr_flag);
endmodule

// File: rtl/sfifo_irq_chk.sv
module sfifo_irq_chk #(
    parameter int DEPTH = 1024,
    localparam int CW = $clog2(DEPTH) + 1,
    localparam int HALF = DEPTH / 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] fill_cnt,
    input logic          ready_flag,
    input logic          ovr_flag,
    input logic [7:0]    ctrl_q,
    input logic          irq_out,
    input logic          push_ok,
    input logic          push_drop,
    input logic          clr_req,
    input logic          disarm,
    input logic          pop_req
);
    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CW'(DEPTH));

    a_r3_empty_pop_still: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && fill_cnt == '0 && !push_ok) |=> (fill_cnt == '0));

    a_r5_clear_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !push_ok && fill_cnt < CW'(HALF)) |=> !ready_flag);

    a_r6_half_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_cnt >= CW'(HALF)) |=> ready_flag);

    a_r7_drop_sets: assert property (@(posedge clk) disable iff (!rst_n)
        push_drop |=> ovr_flag);

    a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !disarm) |=> ovr_flag);

    a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (ctrl_q[7] && (ready_flag || ovr_flag)));
endmodule

bind sfifo_irq_top sfifo_irq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .fill_cnt(fill_cnt), .ready_flag(ready_flag),
    .ovr_flag(ovr_flag), .ctrl_q(ctrl_q), .irq_out(irq_out),
    .push_ok(push_ok), .push_drop(push_drop), .clr_req(clr_req),
    .disarm(disarm), .pop_req(pop_req)
);

// File: tb/tb_sfifo_irq_top.sv
`timescale 1ns/1ps
module tb_sfifo_irq_top;
    localparam int DEPTH = 1024;

    logic        clk = 0, rst_n = 0;
    logic        cv_valid = 0;
    logic [11:0] cv_value = 0;
    logic [3:0]  cv_chan = 0, host_addr = 0, line_num = 0;
    logic        host_rd = 0, host_wr = 0;
    logic [7:0]  host_wdata = 0;
    logic [15:0] host_rdata;
    logic        irq_out;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sfifo_irq_top #(.DEPTH(DEPTH)) dut (.*);

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [11:0] v, input logic [3:0] c);
        @(negedge clk); cv_valid = 1; cv_value = v; cv_chan = c;
        @(negedge clk); cv_valid = 0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk); host_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk); host_rd = 1; host_addr = a;
        @(negedge clk); host_rd = 0; d = host_rdata;
    endtask

    function automatic logic [3:0] exp_code(input int n);
        case (n)
            10: return 4'b1000; 11: return 4'b1001; 12: return 4'b1010;
            15: return 4'b1011; 2: return 4'b1100; 3: return 4'b1101;
            5: return 4'b1110; 7: return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic [15:0] pat(input int i);
        return {12'((i * 37 + 11) & 12'hFFF), 4'(i & 15)};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [2:0]  field;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R11 reset state
        chk("R11 rdata", host_rdata, 16'h0);
        chk("R11 irq", {15'd0, irq_out}, 16'h0);
        rd(4'd2, d); chk("R11 status", d, 16'h0);
        rd(4'd5, d); chk("R11 ctrl", d, 16'h0);
        rd(4'd0, d); chk("R3 empty after reset", d, 16'h0);

        // R9 sweep all line numbers; wdata 6:4 set but ignored
        field = 3'd0;
        for (int l = 0; l < 16; l++) begin
            line_num = 4'(l);
            wr(4'd5, 8'h70);
            if (exp_code(l) & 4'b1000) field = exp_code(l) & 4'b0111;
            rd(4'd5, d);
            chk($sformatf("R9 line %0d", l), d, {9'd0, field, 4'd0});
        end
        line_num = 4'd5; // code 6

        // R5 / R10 / R2 / R3 single sample
        push(12'hABC, 4'd5);
        rd(4'd2, d); chk("R5 ready after push", d, 16'h0080);
        chk("R10 irq disabled", {15'd0, irq_out}, 16'h0);
        wr(4'd5, 8'h83);
        rd(4'd5, d); chk("R8 ctrl readback", d, 16'h00E3);
        chk("R10 irq enabled", {15'd0, irq_out}, 16'h1);
        wr(4'd4, 8'h5A);
        rd(4'd2, d); chk("R5 ready cleared", d, 16'h0000);
        chk("R10 irq low after clear", {15'd0, irq_out}, 16'h0);
        rd(4'd0, d); chk("R2 packed word", d, 16'hABC5);
        rd(4'd0, d); chk("R3 empty read repeats", d, 16'hABC5);
        rd(4'd2, d); chk("R4 status other bits", d, 16'h0000);

        // R1 / R6 / R7 fill to full and beyond
        for (int i = 0; i < DEPTH; i++) begin
            push(pat(i)[15:4], pat(i)[3:0]);
            if (i == 599) begin
                wr(4'd4, 8'h00);
                rd(4'd2, d); chk("R6 clear ignored above half", d, 16'h0080);
            end
        end
        push(12'hFFF, 4'hF);
        rd(4'd2, d); chk("R7 overrun set", d, 16'h00A0);
        wr(4'd4, 8'hFF);
        rd(4'd2, d); chk("R7 clear keeps overrun", d, 16'h00A0);
        for (int i = 0; i < DEPTH; i++) begin
            rd(4'd0, d);
            chk($sformatf("R1 order %0d", i), d, pat(i));
        end
        rd(4'd0, d); chk("R3 drained repeat", d, pat(DEPTH - 1));
        wr(4'd4, 8'h00);
        rd(4'd2, d); chk("R7 overrun sticky", d, 16'h0020);
        chk("R10 irq from overrun", {15'd0, irq_out}, 16'h1);
        wr(4'd5, 8'h82);
        rd(4'd2, d); chk("R7 nonzero pacer keeps overrun", d, 16'h0020);
        wr(4'd5, 8'h80);
        rd(4'd2, d); chk("R7 disarm clears overrun", d, 16'h0000);
        chk("R10 irq idle", {15'd0, irq_out}, 16'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule